// File: doc/BRIEF.md
# Byte Arithmetic and Logic Unit with Status Flags

This block is the arithmetic and logic stage of a small 8-bit processor core. Each accepted request names an operation, a destination operand, a source operand (a register value or an immediate, picked by a select input) and the incoming carry and zero flags. One clock later it presents the 8-bit result, six status flags and a per-flag update mask that tells the flag register which flags to write. A separate result-write strobe lets compares run without touching the register file.

A pointer-pair mode adds or subtracts a 6-bit constant to a 16-bit register pair. It is built as a two-state machine. In the idle state, ST_IDLE, every request is taken. A pair request moves the machine to ST_WORD_HI and produces the low byte, with no flag updates. In ST_WORD_HI the block produces the high byte and the pair's flags, then always goes back to ST_IDLE. While it is in ST_WORD_HI the `busy` output is high and requests are ignored. The only transitions are ST_IDLE to ST_WORD_HI (on a pair request) and ST_WORD_HI to ST_IDLE (always).

Flag vector bit positions: C=0, Z=1, N=2, V=3, S=4, H=5. In every requirement below, N is result bit 7, Z means the result is zero, and S is N xor V, unless the requirement says otherwise.

Top module: `byte_alu`

## Requirements
- R1: Op 0 (add) and op 1 (add plus `carry_in`) return the 8-bit sum with `result_we`=1 and mask 6'b111111. C is the carry out of bit 7, H is the carry out of bit 3, and V is signed overflow.
- R2: Op 2 (subtract) and op 3 (subtract with `carry_in` as borrow) return the difference with mask 6'b111111. C is the borrow into bit 7, H is the borrow into bit 3, and V is signed overflow.
- R3: For ops 3 and 5 the Z flag is set only when the byte result is zero and `zero_in` is 1. It is never set otherwise.
- R4: Op 4 (compare) and op 5 (compare with borrow) produce the same flags and mask as ops 2 and 3, with `result_we`=0.
- R5: Op 6 (AND), op 7 (OR) and op 8 (XOR) use mask 6'b011110 and clear V.
- R6: Op 9 returns the bitwise inverse with C=1, V=0 and mask 6'b011111. Op 10 returns 0 minus the operand with mask 6'b111111: C=1 unless the operand is 0, H is a borrow from bit 3, and V=1 only for 0x80. Op 11 (+1) and op 12 (-1) use mask 6'b011110: V=1 only when the result is 0x80 for op 11, or 0x7F for op 12.
- R7: Op 13 shifts left with a 0 fill and op 15 rotates left through `carry_in`. Both put the old bit 7 into C, the old bit 3 into H, set V = N xor C, and use mask 6'b111111.
- R8: Op 14 shifts right with a 0 fill, op 16 rotates right through `carry_in`, and op 17 shifts right while keeping bit 7. All three put the old bit 0 into C, set V = N xor C after the shift, and use mask 6'b011111.
- R9: Op 18 exchanges the two nibbles and updates no flag (mask 0).
- R10: With `imm_sel`=1 the source operand is `imm_val` instead of `rr_val`.
- R11: Op 19 (pair add) and op 20 (pair subtract) take the low byte from `rd_val`, the high byte from `rr_val`, and K from `imm_val[5:0]`. The low result byte comes out one cycle after the request, with mask 0. The high byte comes out on the next cycle with mask 6'b011111, where C is the 16-bit carry or borrow, V is the 16-bit signed overflow, N is bit 15, and Z means the full 16-bit result is zero.
- R12: During the cycle that produces the high byte, `busy`=1 and a request on `in_valid` is dropped: it produces no output.
- R13: After reset `out_valid`=0 and `busy`=0. Every accepted request yields exactly one output, one cycle later (two for pair ops). When `out_valid`=0, the mask and `result_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe |
| op | input | 5 | Operation code |
| rd_val | input | 8 | Destination operand / pair low byte |
| rr_val | input | 8 | Register source / pair high byte |
| imm_val | input | 8 | Immediate source; bits 5:0 are K in pair mode |
| imm_sel | input | 1 | Source select: 1 selects the immediate |
| carry_in | input | 1 | Current C flag |
| zero_in | input | 1 | Current Z flag, used for chained subtraction |
| busy | output | 1 | High-byte phase of a pair operation |
| out_valid | output | 1 | Result strobe |
| result | output | 8 | Result byte |
| flags | output | 6 | H,S,V,N,Z,C at bits 5..0 |
| flag_we | output | 6 | Per-flag update mask |
| result_we | output | 1 | Result should be written back |

## Verification
The two functions that can meet in one cycle are the high-byte phase of a pair operation and a new request arriving on `in_valid`. The bench provokes this by raising `in_valid` with an add request during the busy cycle that follows a pair request. It expects only the pair's two output items: any extra output item, or a missing one, is reported against R12 or R13.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int DATA_W  = 8;
    localparam int FLAG_W  = 6;
    localparam int KIMM_W  = 6;

    localparam int FC = 0;
    localparam int FZ = 1;
    localparam int FN = 2;
    localparam int FV = 3;
    localparam int FS = 4;
    localparam int FH = 5;

    localparam logic [FLAG_W-1:0] M_ALL   = 6'b111111;
    localparam logic [FLAG_W-1:0] M_CZNVS = 6'b011111;
    localparam logic [FLAG_W-1:0] M_ZNVS  = 6'b011110;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
        OP_CMP  = 5'd4,  OP_CMPC = 5'd5,  OP_AND  = 5'd6,  OP_OR   = 5'd7,
        OP_XOR  = 5'd8,  OP_INV  = 5'd9,  OP_NEG  = 5'd10, OP_INC  = 5'd11,
        OP_DEC  = 5'd12, OP_SHL  = 5'd13, OP_SHR  = 5'd14, OP_RL   = 5'd15,
        OP_RR   = 5'd16, OP_SAR  = 5'd17, OP_NSWP = 5'd18, OP_WADD = 5'd19,
        OP_WSUB = 5'd20
    } alu_op_e;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_WORD_HI = 1'b1
    } alu_state_e;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
        logic [FLAG_W-1:0] flg;
        logic [FLAG_W-1:0] we;
        logic              res_we;
    } alu_out_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] d,
    input  logic [W-1:0] s,
    input  logic         cin,
    input  logic         sub,
    input  logic         chain,
    input  logic         zin,
    output logic [W-1:0] r,
    output logic         hc,
    output logic         vf,
    output logic         cf,
    output logic         zf
);
    localparam int HB = W / 2 - 1;
    localparam int MB = W - 1;

    logic [W-1:0] cin_w;
    assign cin_w = {{(W-1){1'b0}}, cin};

    always_comb begin
        if (sub) begin
            r  = d - s - cin_w;
            hc = (~d[HB] & s[HB]) | (s[HB] & r[HB]) | (r[HB] & ~d[HB]);
            vf = (d[MB] & ~s[MB] & ~r[MB]) | (~d[MB] & s[MB] & r[MB]);
            cf = (~d[MB] & s[MB]) | (s[MB] & r[MB]) | (r[MB] & ~d[MB]);
        end else begin
            r  = d + s + cin_w;
            hc = (d[HB] & s[HB]) | (s[HB] & ~r[HB]) | (~r[HB] & d[HB]);
            vf = (d[MB] & s[MB] & ~r[MB]) | (~d[MB] & ~s[MB] & r[MB]);
            cf = (d[MB] & s[MB]) | (s[MB] & ~r[MB]) | (~r[MB] & d[MB]);
        end
        // chained subtraction may only keep or clear the incoming zero flag
        zf = (r == '0) & (~chain | zin);
    end
endmodule

// File: rtl/alu_logic_shift.sv
module alu_logic_shift
    import alu_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op,
    input  logic [W-1:0] d,
    input  logic [W-1:0] s,
    input  logic         cin,
    output logic [W-1:0] r,
    output logic         cout
);
    localparam int MB = W - 1;
    localparam int NB = W / 2;

    always_comb begin
        r    = d;
        cout = 1'b0;
        unique case (op)
            OP_AND:  r = d & s;
            OP_OR:   r = d | s;
            OP_XOR:  r = d ^ s;
            OP_INV:  r = ~d;
            OP_SHL:  begin r = {d[MB-1:0], 1'b0}; cout = d[MB]; end
            OP_RL:   begin r = {d[MB-1:0], cin};  cout = d[MB]; end
            OP_SHR:  begin r = {1'b0, d[MB:1]};   cout = d[0];  end
            OP_RR:   begin r = {cin, d[MB:1]};    cout = d[0];  end
            OP_SAR:  begin r = {d[MB], d[MB:1]};  cout = d[0];  end
            OP_NSWP: r = {d[NB-1:0], d[W-1:NB]};
            default: r = d;
        endcase
    end
endmodule

// File: rtl/byte_alu.sv
module byte_alu
    import alu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [4:0]  op,
    input  logic [7:0]  rd_val,
    input  logic [7:0]  rr_val,
    input  logic [7:0]  imm_val,
    input  logic        imm_sel,
    input  logic        carry_in,
    input  logic        zero_in,
    output logic        busy,
    output logic        out_valid,
    output logic [7:0]  result,
    output logic [5:0]  flags,
    output logic [5:0]  flag_we,
    output logic        result_we
);
    localparam int HB = DATA_W / 2 - 1;
    localparam int MB = DATA_W - 1;

    alu_state_e state_q, state_d;
    alu_op_e    op_e;
    logic [DATA_W-1:0] opnd;
    logic              is_word;

    // pair context held across the high-byte phase
    logic [DATA_W-1:0] hi_q;
    logic              cy_q, lo_zero_q, sub_q;

    // shared adder inputs and outputs
    logic [DATA_W-1:0] a_d, a_s, a_r;
    logic              a_cin, a_sub, a_chain;
    logic              a_h, a_v, a_c, a_z;

    logic [DATA_W-1:0] l_r;
    logic              l_c;

    alu_out_t nxt, out_q;
    logic [DATA_W-1:0] rv;
    logic hv, vv, cv, zv;

    assign op_e    = alu_op_e'(op);
    assign opnd    = imm_sel ? imm_val : rr_val;
    assign is_word = (op_e == OP_WADD) || (op_e == OP_WSUB);

    // operand steering for the shared adder
    always_comb begin
        a_d     = rd_val;
        a_s     = opnd;
        a_cin   = 1'b0;
        a_sub   = 1'b0;
        a_chain = 1'b0;
        if (state_q == ST_WORD_HI) begin
            a_d   = hi_q;
            a_s   = '0;
            a_cin = cy_q;
            a_sub = sub_q;
        end else begin
            unique case (op_e)
                OP_ADC:          a_cin = carry_in;
                OP_SUB, OP_CMP:  a_sub = 1'b1;
                OP_SBC, OP_CMPC: begin a_sub = 1'b1; a_cin = carry_in; a_chain = 1'b1; end
                OP_NEG:          begin a_d = '0; a_s = rd_val; a_sub = 1'b1; end
                OP_INC:          a_s = {{(DATA_W-1){1'b0}}, 1'b1};
                OP_DEC:          begin a_s = {{(DATA_W-1){1'b0}}, 1'b1}; a_sub = 1'b1; end
                OP_WADD:         a_s = {{(DATA_W-KIMM_W){1'b0}}, imm_val[KIMM_W-1:0]};
                OP_WSUB:         begin a_s = {{(DATA_W-KIMM_W){1'b0}}, imm_val[KIMM_W-1:0]}; a_sub = 1'b1; end
                default:         a_sub = 1'b0;
            endcase
        end
    end

    alu_addsub #(.W(DATA_W)) u_addsub (
        .d(a_d), .s(a_s), .cin(a_cin), .sub(a_sub), .chain(a_chain), .zin(zero_in),
        .r(a_r), .hc(a_h), .vf(a_v), .cf(a_c), .zf(a_z)
    );

    alu_logic_shift #(.W(DATA_W)) u_lsh (
        .op(op_e), .d(rd_val), .s(opnd), .cin(carry_in), .r(l_r), .cout(l_c)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: ST_IDLE -> ST_WORD_HI on a pair request, ST_WORD_HI -> ST_IDLE always
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = (in_valid && is_word) ? ST_WORD_HI : ST_IDLE;
            ST_WORD_HI: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q      <= '0;
            cy_q      <= 1'b0;
            lo_zero_q <= 1'b0;
            sub_q     <= 1'b0;
        end else if (state_q == ST_IDLE && in_valid && is_word) begin
            hi_q      <= rr_val;
            cy_q      <= a_c;
            lo_zero_q <= (a_r == '0);
            sub_q     <= (op_e == OP_WSUB);
        end
    end

    // next output item
    always_comb begin
        nxt = '0;
        rv  = '0;
        hv  = 1'b0;
        vv  = 1'b0;
        cv  = 1'b0;
        zv  = 1'b0;
        if (state_q == ST_WORD_HI) begin
            nxt.vld    = 1'b1;
            nxt.res_we = 1'b1;
            rv = a_r; vv = a_v; cv = a_c; zv = a_z & lo_zero_q;
            nxt.we = M_CZNVS;
        end else if (in_valid) begin
            nxt.vld = 1'b1;
            unique case (op_e)
                OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
                    rv = a_r; hv = a_h; vv = a_v; cv = a_c; zv = a_z;
                    nxt.we = M_ALL; nxt.res_we = 1'b1;
                end
                OP_CMP, OP_CMPC: begin
                    rv = a_r; hv = a_h; vv = a_v; cv = a_c; zv = a_z;
                    nxt.we = M_ALL;
                end
                OP_INC, OP_DEC: begin
                    rv = a_r; vv = a_v; zv = a_z;
                    nxt.we = M_ZNVS; nxt.res_we = 1'b1;
                end
                OP_AND, OP_OR, OP_XOR: begin
                    rv = l_r; zv = (l_r == '0);
                    nxt.we = M_ZNVS; nxt.res_we = 1'b1;
                end
                OP_INV: begin
                    rv = l_r; cv = 1'b1; zv = (l_r == '0);
                    nxt.we = M_CZNVS; nxt.res_we = 1'b1;
                end
                OP_SHL, OP_RL: begin
                    rv = l_r; cv = l_c; hv = rd_val[HB]; vv = l_r[MB] ^ l_c; zv = (l_r == '0);
                    nxt.we = M_ALL; nxt.res_we = 1'b1;
                end
                OP_SHR, OP_RR, OP_SAR: begin
                    rv = l_r; cv = l_c; vv = l_r[MB] ^ l_c; zv = (l_r == '0);
                    nxt.we = M_CZNVS; nxt.res_we = 1'b1;
                end
                OP_NSWP: begin
                    rv = l_r; zv = (l_r == '0); nxt.res_we = 1'b1;
                end
                OP_WADD, OP_WSUB: begin
                    rv = a_r; nxt.res_we = 1'b1;
                end
                default: nxt.res_we = 1'b0;
            endcase
        end
        nxt.res     = rv;
        nxt.flg[FC] = cv;
        nxt.flg[FZ] = zv;
        nxt.flg[FN] = rv[MB];
        nxt.flg[FV] = vv;
        nxt.flg[FS] = rv[MB] ^ vv;
        nxt.flg[FH] = hv;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= nxt;
    end

    assign busy      = (state_q == ST_WORD_HI);
    assign out_valid = out_q.vld;
    assign result    = out_q.res;
    assign flags     = out_q.flg;
    assign flag_we   = out_q.we;
    assign result_we = out_q.res_we;

endmodule

// File: rtl/byte_alu_chk.sv
module byte_alu_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       busy,
    input logic       out_valid,
    input logic [7:0] result,
    input logic [5:0] flags,
    input logic [5:0] flag_we,
    input logic       result_we
);
    p_accept_latency_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !busy) |=> out_valid);

    p_quiet_outputs_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (flag_we == 6'b0 && !result_we));

    p_hi_phase_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    p_low_byte_noflags_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (out_valid && flag_we == 6'b0 && result_we));

    p_busy_drops_request_r12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (out_valid && flag_we == 6'b011111));

    p_neg_is_msb_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flag_we[2]) |-> (flags[2] == result[7]));

    p_zero_means_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flag_we[1] && flags[1]) |-> (result == 8'h00));
endmodule

bind byte_alu byte_alu_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .busy(busy),
    .out_valid(out_valid), .result(result), .flags(flags),
    .flag_we(flag_we), .result_we(result_we)
);

// File: tb/byte_alu_test.sv
`timescale 1ns/1ps
module byte_alu_test;

    typedef struct packed {
        logic [7:0] res;
        logic [5:0] flg;
        logic [5:0] we;
        logic       rw;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [4:0] op = 5'd0;
    logic [7:0] rd_val = 8'h00, rr_val = 8'h00, imm_val = 8'h00;
    logic       imm_sel = 1'b0, carry_in = 1'b0, zero_in = 1'b0;
    logic       busy, out_valid, result_we;
    logic [7:0] result;
    logic [5:0] flags, flag_we;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    exp_t  q[$];
    string tq[$];
    exp_t  e;
    string t;

    always #4 clk = ~clk;

    byte_alu uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .rd_val(rd_val), .rr_val(rr_val), .imm_val(imm_val), .imm_sel(imm_sel),
        .carry_in(carry_in), .zero_in(zero_in), .busy(busy), .out_valid(out_valid),
        .result(result), .flags(flags), .flag_we(flag_we), .result_we(result_we)
    );

    // reference model built from the requirement text (C0 Z1 N2 V3 S4 H5)
    function automatic exp_t model(input logic [4:0] o, input logic [7:0] d,
                                   input logic [7:0] s, input logic ci, input logic zi);
        exp_t x;
        int du, su, cc, sd, ss, sr;
        logic c, v, h, zg, n, z;
        logic [7:0] r;
        du = int'(d); su = int'(s); sd = int'($signed(d)); ss = int'($signed(s));
        c = 1'b0; v = 1'b0; h = 1'b0; zg = 1'b1; r = d;
        x.rw = 1'b1; x.we = 6'b111111;
        case (o)
            5'd0, 5'd1: begin
                cc = (o == 5'd1) ? int'(ci) : 0;
                r = 8'(du + su + cc);
                c = (du + su + cc) > 255;
                h = ((du % 16) + (su % 16) + cc) > 15;
                sr = sd + ss + cc; v = (sr > 127) || (sr < -128);
            end
            5'd2, 5'd3, 5'd4, 5'd5: begin
                cc = (o == 5'd3 || o == 5'd5) ? int'(ci) : 0;
                r = 8'(du - su - cc);
                c = du < (su + cc);
                h = (du % 16) < ((su % 16) + cc);
                sr = sd - ss - cc; v = (sr > 127) || (sr < -128);
                if (o == 5'd3 || o == 5'd5) zg = zi;
                x.rw = (o < 5'd4);
            end
            5'd6: begin r = d & s; x.we = 6'b011110; end
            5'd7: begin r = d | s; x.we = 6'b011110; end
            5'd8: begin r = d ^ s; x.we = 6'b011110; end
            5'd9: begin r = ~d; c = 1'b1; x.we = 6'b011111; end
            5'd10: begin r = 8'(0 - du); c = (d != 8'h00); h = (du % 16) != 0; v = (d == 8'h80); end
            5'd11: begin r = d + 8'd1; v = (d == 8'h7F); x.we = 6'b011110; end
            5'd12: begin r = d - 8'd1; v = (d == 8'h80); x.we = 6'b011110; end
            5'd13: begin r = {d[6:0], 1'b0}; c = d[7]; h = d[3]; v = r[7] ^ c; end
            5'd15: begin r = {d[6:0], ci};   c = d[7]; h = d[3]; v = r[7] ^ c; end
            5'd14: begin r = {1'b0, d[7:1]}; c = d[0]; v = r[7] ^ c; x.we = 6'b011111; end
            5'd16: begin r = {ci, d[7:1]};   c = d[0]; v = r[7] ^ c; x.we = 6'b011111; end
            5'd17: begin r = {d[7], d[7:1]}; c = d[0]; v = r[7] ^ c; x.we = 6'b011111; end
            5'd18: begin r = {d[3:0], d[7:4]}; x.we = 6'b000000; end
            default: begin x.we = 6'b000000; x.rw = 1'b0; end
        endcase
        n = r[7];
        z = (r == 8'h00) && zg;
        x.res = r;
        x.flg = {h, n ^ v, v, n, z, c};
        return x;
    endfunction

    task automatic drive(input string tag, input logic [4:0] o, input logic [7:0] d,
                         input logic [7:0] s, input logic [7:0] im, input logic isel,
                         input logic ci, input logic zi);
        op = o; rd_val = d; rr_val = s; imm_val = im; imm_sel = isel;
        carry_in = ci; zero_in = zi; in_valid = 1'b1;
        q.push_back(model(o, d, isel ? im : s, ci, zi));
        tq.push_back(tag);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drive_word(input string tag, input logic sub, input logic [15:0] w,
                              input logic [5:0] k, input logic poke);
        exp_t lo, hi;
        logic [16:0] r;
        int ws, wr;
        logic v, n, z;
        op = sub ? 5'd20 : 5'd19;
        rd_val = w[7:0]; rr_val = w[15:8]; imm_val = {2'b00, k}; imm_sel = 1'b0;
        in_valid = 1'b1;
        r = sub ? ({1'b0, w} - {11'b0, k}) : ({1'b0, w} + {11'b0, k});
        ws = int'($signed(w));
        wr = sub ? (ws - int'(k)) : (ws + int'(k));
        v = (wr > 32767) || (wr < -32768);
        n = r[15];
        z = (r[15:0] == 16'h0000);
        lo.res = r[7:0]; lo.flg = 6'b0; lo.we = 6'b0; lo.rw = 1'b1;
        hi.res = r[15:8]; hi.flg = {1'b0, n ^ v, v, n, z, r[16]}; hi.we = 6'b011111; hi.rw = 1'b1;
        q.push_back(lo); tq.push_back({tag, " low"});
        q.push_back(hi); tq.push_back({tag, " high"});
        @(negedge clk);
        n_tests++;
        if (busy !== 1'b1) begin
            n_fail++;
            $display("FAIL R12: busy=%b expected 1 in high-byte cycle", busy);
        end
        if (poke) begin
            op = 5'd0; rd_val = 8'h55; rr_val = 8'h11; in_valid = 1'b1;
        end else begin
            in_valid = 1'b0;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !done && out_valid) begin
            n_tests++;
            if (q.size() == 0) begin
                n_fail++;
                $display("FAIL R12: unexpected output res=%h expected none", result);
            end else begin
                e = q.pop_front();
                t = tq.pop_front();
                if (result !== e.res || result_we !== e.rw || flag_we !== e.we ||
                    (flags & e.we) !== (e.flg & e.we)) begin
                    n_fail++;
                    $display("FAIL %s: res=%h flg=%b we=%b rw=%b expected res=%h flg=%b we=%b rw=%b",
                             t, result, flags & flag_we, flag_we, result_we,
                             e.res, e.flg & e.we, e.we, e.rw);
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        n_tests++;
        if (out_valid !== 1'b0 || busy !== 1'b0) begin
            n_fail++;
            $display("FAIL R13: reset out_valid=%b busy=%b expected 0 0", out_valid, busy);
        end
        rst_n = 1'b1;
        @(negedge clk);

        drive("R1 half carry",     5'd0, 8'h0F, 8'h01, 8'h00, 1'b0, 1'b0, 1'b0);
        drive("R1 overflow",       5'd0, 8'h7F, 8'h01, 8'h00, 1'b0, 1'b0, 1'b0);
        drive("R1 carry zero",     5'd0, 8'hFF, 8'h01, 8'h00, 1'b0, 1'b0, 1'b0);
        drive("R1 with carry",     5'd1, 8'h80, 8'h7F, 8'h00, 1'b0, 1'b1, 1'b0);
        drive("R2 borrow",         5'd2, 8'h00, 8'h01, 8'h00, 1'b0, 1'b0, 1'b0);
        drive("R2 overflow",       5'd2, 8'h80, 8'h01, 8'h00, 1'b0, 1'b0, 1'b0);
        drive("R3 chain keeps Z",  5'd3, 8'h05, 8'h04, 8'h00, 1'b0, 1'b1, 1'b1);
        drive("R3 chain clears Z", 5'd3, 8'h05, 8'h04, 8'h00, 1'b0, 1'b1, 1'b0);
        drive("R4 compare",        5'd4, 8'h10, 8'h20, 8'h00, 1'b0, 1'b0, 1'b0);
        drive("R4 compare carry",  5'd5, 8'h33, 8'h33, 8'h00, 1'b0, 1'b0, 1'b1);
        drive("R5 and",            5'd6, 8'hF0, 8'h0F, 8'h00, 1'b0, 1'b1, 1'b0);
        drive("R5 or",             5'd7, 8'h80, 8'h01, 8'h00, 1'b0, 1'b0, 1'b0);
        drive("R5 xor",            5'd8, 8'hAA, 8'hFF, 8'h00, 1'b0, 1'b0, 1'b0);
        drive("R6 invert",         5'd9, 8'hFF, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
        drive("R6 negate 80",      5'd10, 8'h80, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
        drive("R6 negate 0",       5'd10, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
        drive("R6 increment 7F",   5'd11, 8'h7F, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
        drive("R6 decrement 80",   5'd12, 8'h80, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
        drive("R7 shift left",     5'd13, 8'h88, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
        drive("R7 rotate left",    5'd15, 8'h40, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0);
        drive("R8 shift right",    5'd14, 8'h01, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
        drive("R8 rotate right",   5'd16, 8'h02, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0);
        drive("R8 sign shift",     5'd17, 8'h81, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
        drive("R9 nibble swap",    5'd18, 8'h3C, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0);
        drive("R10 immediate sub", 5'd2, 8'h40, 8'hFF, 8'h40, 1'b1, 1'b0, 1'b0);
        drive("R10 immediate and", 5'd6, 8'hF3, 8'h00, 8'h0F, 1'b1, 1'b0, 1'b0);

        drive_word("R11 pair add carry",  1'b0, 16'h00FF, 6'd1,  1'b0);
        drive_word("R11 pair add wrap",   1'b0, 16'hFFC1, 6'd63, 1'b0);
        drive_word("R11 pair add ovf",    1'b0, 16'h7FFF, 6'd1,  1'b1);
        drive_word("R11 pair sub borrow", 1'b1, 16'h0000, 6'd1,  1'b0);
        drive_word("R11 pair sub ovf",    1'b1, 16'h8000, 6'd1,  1'b1);
        drive_word("R11 pair sub zero",   1'b1, 16'h002A, 6'd42, 1'b1);

        lfsr = 16'hACE1;
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            drive("R13 mixed", 5'(int'(lfsr[7:0]) % 19), lfsr[15:8], lfsr[7:0] ^ 8'h5A,
                  lfsr[11:4], lfsr[3], lfsr[5], lfsr[9]);
        end

        repeat (3) @(negedge clk);
        n_tests++;
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL R13: %0d items never produced, expected 0", q.size());
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule